// File: doc/BRIEF.md
# Double-Precision to 32-bit Integer Converter

This unit turns a 64-bit IEEE-754 double-precision operand into a 32-bit integer. The integer is either signed or unsigned, chosen by a select input. The result is delivered as a 64-bit value, ready to be written into a 64-bit integer register file. Bit 31 of the 32-bit result is always copied into bits 63:32, for the unsigned form as well as the signed form. One of five rounding modes is applied, and two exception flags are raised: invalid and inexact.

Inside the unit, a classifier sorts the operand into one of several bands:

- NaN
- overflowing (infinity, or a magnitude of at least 2^32)
- in the shift range
- near one half
- tiny
- zero

A datapath then does the arithmetic in this order:

1. Align the significand.
2. Round the magnitude in a 33-bit field.
3. Check the range, then either saturate or negate.
4. Widen to 64 bits.

The widening is taken from bit 31 of the value after negation. For that reason -2^31 comes out as 0xFFFFFFFF80000000. The result and the flags are registered once, so each operand presented at a rising clock edge is converted at that same edge.

Top module: `dbl_to_int32_cvt`

## Requirements
- R1: While reset is asserted, the result and both flags are zero.
- R2: Latency is one cycle. Inputs sampled at a rising edge set the outputs right after that edge, and the outputs do not change between edges.
- R3: A signed conversion in the range [-2^31, 2^31-1] gives the two's-complement value sign-extended to 64 bits. -2^31 (0xC1E0000000000000) gives 0xFFFFFFFF80000000, and 2^31-1 gives 0x000000007FFFFFFF.
- R4: An unsigned result is also sign-extended from bit 31. For example, 3,000,000,000 gives 0xFFFFFFFFB2D05E00.
- R5: The rounding select codes are 0 round-to-nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity and 4 round-to-nearest-with-ties-away. Codes 5 to 7 act as code 0.
- R6: When invalid is not raised, inexact is raised exactly when a discarded fraction bit was non-zero.
- R7: A signed value that rounds above 2^31-1 gives 0x000000007FFFFFFF. A signed value that rounds below -2^31 gives 0xFFFFFFFF80000000. Both raise invalid.
- R8: An unsigned value that rounds above 2^32-1 gives all ones with invalid. A negative value that rounds to a non-zero magnitude gives 0 with invalid. A negative value that rounds to zero gives 0 without invalid.
- R9: A NaN (exponent all ones, mantissa non-zero) gives the largest positive value with invalid. That value is 0x000000007FFFFFFF for signed and all ones for unsigned.
- R10: +infinity saturates high and -infinity saturates low, for the selected signedness, and both raise invalid.
- R11: Both zeros give 0 with no flags. A non-zero subnormal is rounded as a tiny value: 0 with inexact under mode 0, and 1 under mode 3.
- R12: Invalid and inexact are never raised together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opIn | input | 64 | Double-precision operand |
| isUnsigned | input | 1 | 1 selects the unsigned 32-bit target, 0 the signed one |
| rndMode | input | 3 | Rounding mode code (see R5) |
| resOut | output | 64 | Integer result, sign-extended from bit 31 |
| invalidOut | output | 1 | Invalid-operation flag |
| inexactOut | output | 1 | Inexact flag |

## Verification
Rounding and saturation can fall in the same cycle. A rounding carry can push a magnitude that starts inside the range past a limit, and the flags must then resolve to invalid alone.

The bench provokes this with operands half a unit below 2^31 and below 2^32, and with -2^31 minus one half, under the nearest, away and directed modes. It judges each case on three things: the saturated result, invalid raised, and inexact clear. The same operands under truncation give an in-range result with inexact, which shows the carry, not the operand, caused the overflow.

// File: rtl/dcvt_pkg.sv
package dcvt_pkg;
  localparam int FP_W    = 64;
  localparam int EXP_W   = 11;
  localparam int MAN_W   = 52;
  localparam int INT_W   = 32;
  localparam int EXP_BIAS = (1 << (EXP_W - 1)) - 1;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_ZERO      = 3'd1,
    RM_DOWN      = 3'd2,
    RM_UP        = 3'd3,
    RM_NEAR_MAX  = 3'd4
  } rmode_e;

  // Strobes from the classifier to the datapath; at most one is set,
  // none set means the operand is a zero.
  typedef struct packed {
    logic nanIn;      // NaN operand
    logic ovfForce;   // infinity or magnitude >= 2^INT_W
    logic shiftBand;  // 1 <= |x| < 2^INT_W
    logic halfBand;   // 0.5 <= |x| < 1
    logic tinyBand;   // 0 < |x| < 0.5, subnormals included
  } ctrl_t;
endpackage

// File: rtl/dcvt_classify.sv
module dcvt_classify
  import dcvt_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int IW = INT_W
) (
  input  logic [EW-1:0] expIn,
  input  logic          manNz,
  output ctrl_t         ctrl
);
  localparam int BIAS = (1 << (EW - 1)) - 1;
  localparam logic [EW-1:0] EXP_HALF = EW'(BIAS - 1);
  localparam logic [EW-1:0] EXP_TOP  = EW'(BIAS + IW - 1);

  always_comb begin
    ctrl = '0;
    if (&expIn) begin
      ctrl.nanIn    = manNz;
      ctrl.ovfForce = !manNz;
    end else if (expIn == '0) begin
      ctrl.tinyBand = manNz;
    end else if (expIn < EXP_HALF) begin
      ctrl.tinyBand = 1'b1;
    end else if (expIn == EXP_HALF) begin
      ctrl.halfBand = 1'b1;
    end else if (expIn <= EXP_TOP) begin
      ctrl.shiftBand = 1'b1;
    end else begin
      ctrl.ovfForce = 1'b1;
    end
  end
endmodule

// File: rtl/dcvt_datapath.sv
module dcvt_datapath
  import dcvt_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int MW = MAN_W,
  parameter int IW = INT_W,
  parameter int OW = FP_W
) (
  input  logic          signIn,
  input  logic [EW-1:0] expIn,
  input  logic [MW-1:0] manIn,
  input  logic          isUnsigned,
  input  logic [2:0]    rndMode,
  input  ctrl_t         ctrl,
  output logic [OW-1:0] resWide,
  output logic          invalid,
  output logic          inexact
);
  localparam int SIG_W = MW + 1;
  localparam int MAG_W = IW + 1;
  localparam int SH_W  = $clog2(IW);
  localparam int BIAS  = (1 << (EW - 1)) - 1;
  localparam logic [EW-1:0]    BIAS_V  = EW'(BIAS);
  localparam logic [MAG_W-1:0] S_POS_LIM = MAG_W'((64'd1 << (IW - 1)) - 1);
  localparam logic [MAG_W-1:0] S_NEG_LIM = MAG_W'(64'd1 << (IW - 1));
  localparam logic [IW-1:0]    S_MAX = {1'b0, {(IW-1){1'b1}}};
  localparam logic [IW-1:0]    S_MIN = {1'b1, {(IW-1){1'b0}}};

  logic [SIG_W-1:0] sig;
  logic [SH_W-1:0]  posIdx;
  logic [MAG_W-1:0] intPart, mag;
  logic             guard, sticky, roundUp, anyFrac, overflow;
  logic [IW-1:0]    satVal, res32;
  int               gIdx;

  assign sig    = {1'b1, manIn};
  assign posIdx = SH_W'(expIn - BIAS_V);

  // Alignment: integer part plus guard and sticky from the discarded bits.
  always_comb begin
    intPart = '0;
    guard   = 1'b0;
    sticky  = 1'b0;
    gIdx    = MW - 1 - int'(posIdx);
    if (ctrl.shiftBand) begin
      intPart = MAG_W'(sig >> (gIdx + 1));
      guard   = sig[gIdx];
      sticky  = |(sig & ((SIG_W'(1) << gIdx) - SIG_W'(1)));
    end else if (ctrl.halfBand) begin
      guard  = 1'b1;
      sticky = |manIn;
    end else if (ctrl.tinyBand) begin
      sticky = 1'b1;
    end
  end

  // Rounding of the magnitude; mode codes 5..7 fall to nearest-even.
  assign anyFrac = guard | sticky;
  always_comb begin
    case (rndMode)
      RM_ZERO:     roundUp = 1'b0;
      RM_DOWN:     roundUp = signIn & anyFrac;
      RM_UP:       roundUp = !signIn & anyFrac;
      RM_NEAR_MAX: roundUp = guard;
      default:     roundUp = guard & (sticky | intPart[0]);
    endcase
  end
  assign mag = intPart + MAG_W'(roundUp);

  // Range check against the selected target.
  always_comb begin
    if (isUnsigned) overflow = signIn ? (mag != '0) : mag[IW];
    else            overflow = signIn ? (mag > S_NEG_LIM) : (mag > S_POS_LIM);
  end

  always_comb begin
    if (isUnsigned) satVal = signIn ? '0 : '1;
    else            satVal = signIn ? S_MIN : S_MAX;
  end

  // Result select: negation first, widening after it.
  always_comb begin
    invalid = 1'b0;
    inexact = 1'b0;
    if (ctrl.nanIn) begin
      invalid = 1'b1;
      res32   = isUnsigned ? '1 : S_MAX;
    end else if (ctrl.ovfForce || overflow) begin
      invalid = 1'b1;
      res32   = satVal;
    end else begin
      inexact = anyFrac;
      res32   = signIn ? (IW'(0) - mag[IW-1:0]) : mag[IW-1:0];
    end
  end

  assign resWide = {{(OW - IW){res32[IW-1]}}, res32};
endmodule

// File: rtl/dbl_to_int32_cvt.sv
module dbl_to_int32_cvt
  import dcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [FP_W-1:0]  opIn,
  input  logic             isUnsigned,
  input  logic [2:0]       rndMode,
  output logic [FP_W-1:0]  resOut,
  output logic             invalidOut,
  output logic             inexactOut
);
  ctrl_t           ctrl;
  logic [FP_W-1:0] resNext;
  logic            invNext, inxNext;

  dcvt_classify #(.EW(EXP_W), .IW(INT_W)) uClassify (
    .expIn (opIn[FP_W-2 -: EXP_W]),
    .manNz (|opIn[MAN_W-1:0]),
    .ctrl  (ctrl)
  );

  dcvt_datapath #(.EW(EXP_W), .MW(MAN_W), .IW(INT_W), .OW(FP_W)) uDatapath (
    .signIn     (opIn[FP_W-1]),
    .expIn      (opIn[FP_W-2 -: EXP_W]),
    .manIn      (opIn[MAN_W-1:0]),
    .isUnsigned (isUnsigned),
    .rndMode    (rndMode),
    .ctrl       (ctrl),
    .resWide    (resNext),
    .invalid    (invNext),
    .inexact    (inxNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resOut     <= '0;
      invalidOut <= 1'b0;
      inexactOut <= 1'b0;
    end else begin
      resOut     <= resNext;
      invalidOut <= invNext;
      inexactOut <= inxNext;
    end
  end
endmodule

// File: rtl/dcvt_checker.sv
module dcvt_checker
  import dcvt_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic [FP_W-1:0] opIn,
  input logic            isUnsigned,
  input logic [FP_W-1:0] resOut,
  input logic            invalidOut,
  input logic            inexactOut
);
  logic primed;
  logic opNan, opPosInf, opZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  assign opNan    = (&opIn[FP_W-2 -: EXP_W]) && (opIn[MAN_W-1:0] != '0);
  assign opPosInf = (opIn == {1'b0, {EXP_W{1'b1}}, {MAN_W{1'b0}}});
  assign opZero   = (opIn[FP_W-2:0] == '0);

  a_r12_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    invalidOut |-> !inexactOut);

  a_r4_widen_from_bit31: assert property (@(posedge clk) disable iff (!rstN)
    resOut[FP_W-1:INT_W] == {(FP_W-INT_W){resOut[INT_W-1]}});

  a_r9_nan_max: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(opNan)) |->
      (invalidOut && resOut == ($past(isUnsigned) ? {FP_W{1'b1}} : 64'h0000_0000_7FFF_FFFF)));

  a_r10_pos_inf_signed: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(opPosInf && !isUnsigned)) |->
      (invalidOut && resOut == 64'h0000_0000_7FFF_FFFF));

  a_r11_zero_clean: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(opZero)) |-> (resOut == '0 && !invalidOut && !inexactOut));

  a_r8_unsigned_negative: assert property (@(posedge clk) disable iff (!rstN)
    (primed && $past(isUnsigned && opIn[FP_W-1] && !opNan)) |-> (resOut == '0));

  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_clear: assert (resOut == '0 && !invalidOut && !inexactOut);
    end
  end
endmodule

bind dbl_to_int32_cvt dcvt_checker uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .opIn       (opIn),
  .isUnsigned (isUnsigned),
  .resOut     (resOut),
  .invalidOut (invalidOut),
  .inexactOut (inexactOut)
);

// File: tb/dbl_to_int32_cvt_test.sv
`timescale 1ns/1ps
module dbl_to_int32_cvt_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opIn = '0;
  logic        isUnsigned = 1'b0;
  logic [2:0]  rndMode = 3'd0;
  logic [63:0] resOut;
  logic        invalidOut, inexactOut;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  localparam logic [2:0] NE = 3'd0, TZ = 3'd1, DN = 3'd2, UP = 3'd3, MM = 3'd4;
  localparam logic [63:0] S_MAX_W = 64'h0000_0000_7FFF_FFFF;
  localparam logic [63:0] S_MIN_W = 64'hFFFF_FFFF_8000_0000;
  localparam logic [63:0] ONES    = 64'hFFFF_FFFF_FFFF_FFFF;

  always #2.5 clk = ~clk;

  dbl_to_int32_cvt uut (
    .clk(clk), .rstN(rstN), .opIn(opIn), .isUnsigned(isUnsigned),
    .rndMode(rndMode), .resOut(resOut), .invalidOut(invalidOut),
    .inexactOut(inexactOut)
  );

  task automatic compare(input logic [63:0] expR, input logic expI,
                         input logic expX, input string tag);
    nChecks++;
    if (resOut !== expR || invalidOut !== expI || inexactOut !== expX) begin
      nFail++;
      $display("FAIL %s: got res=%h nv=%b nx=%b, expected res=%h nv=%b nx=%b",
               tag, resOut, invalidOut, inexactOut, expR, expI, expX);
    end
  endtask

  task automatic checkOne(input logic [63:0] op, input logic uns, input logic [2:0] rm,
                          input logic [63:0] expR, input logic expI, input logic expX,
                          input string tag);
    @(negedge clk);
    opIn = op; isUnsigned = uns; rndMode = rm;
    @(posedge clk);
    #1;
    compare(expR, expI, expX, tag);
  endtask

  task automatic testReset();
    @(negedge clk);
    opIn = 64'h7FF8_0000_0000_0000;
    @(posedge clk);
    #1;
    compare('0, 1'b0, 1'b0, "R1 outputs held clear in reset");
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testLatency();
    checkOne(64'h4004_0000_0000_0000, 1'b0, TZ, 64'd2, 1'b0, 1'b1, "R2 first value");
    @(negedge clk);
    opIn = 64'hC1E0_0000_0000_0000; isUnsigned = 1'b0; rndMode = NE;
    #1;
    compare(64'd2, 1'b0, 1'b1, "R2 output holds before edge");
    @(posedge clk);
    #1;
    compare(S_MIN_W, 1'b0, 1'b0, "R2 output updates after edge");
  endtask

  task automatic testSignedLimits();
    checkOne(64'hC1E0_0000_0000_0000, 1'b0, NE, S_MIN_W, 1'b0, 1'b0, "R3 minus 2^31");
    checkOne(64'h41DF_FFFF_FFC0_0000, 1'b0, NE, S_MAX_W, 1'b0, 1'b0, "R3 2^31-1");
    checkOne(64'hC004_0000_0000_0000, 1'b0, TZ, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b1, "R3 -2.5 truncated");
  endtask

  task automatic testUnsignedWiden();
    checkOne(64'h41E6_5A0B_C000_0000, 1'b1, NE, 64'hFFFF_FFFF_B2D0_5E00, 1'b0, 1'b0, "R4 3e9 unsigned");
    checkOne(64'h41E0_0000_0000_0000, 1'b1, NE, S_MIN_W, 1'b0, 1'b0, "R4 2^31 unsigned");
    checkOne(64'h41EF_FFFF_FFE0_0000, 1'b1, NE, ONES, 1'b0, 1'b0, "R4 2^32-1 unsigned");
  endtask

  task automatic testRounding();
    checkOne(64'h4004_0000_0000_0000, 1'b0, NE, 64'd2, 1'b0, 1'b1, "R5 2.5 nearest-even");
    checkOne(64'h4004_0000_0000_0000, 1'b0, MM, 64'd3, 1'b0, 1'b1, "R5 2.5 ties-away");
    checkOne(64'h4004_0000_0000_0000, 1'b0, UP, 64'd3, 1'b0, 1'b1, "R5 2.5 up");
    checkOne(64'h4004_0000_0000_0000, 1'b0, DN, 64'd2, 1'b0, 1'b1, "R5 2.5 down");
    checkOne(64'h4004_0000_0000_0000, 1'b0, 3'd5, 64'd2, 1'b0, 1'b1, "R5 code 5 as nearest-even");
    checkOne(64'hC004_0000_0000_0000, 1'b0, DN, 64'hFFFF_FFFF_FFFF_FFFD, 1'b0, 1'b1, "R5 -2.5 down");
    checkOne(64'hC004_0000_0000_0000, 1'b0, UP, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 1'b1, "R5 -2.5 up");
    checkOne(64'h3FF8_0000_0000_0000, 1'b0, NE, 64'd2, 1'b0, 1'b1, "R5 1.5 nearest-even");
    checkOne(64'h3FE0_0000_0000_0000, 1'b0, NE, 64'd0, 1'b0, 1'b1, "R6 0.5 nearest-even");
    checkOne(64'h3FE0_0000_0000_0000, 1'b0, MM, 64'd1, 1'b0, 1'b1, "R6 0.5 ties-away");
    checkOne(64'h4000_0000_0000_0000, 1'b0, UP, 64'd2, 1'b0, 1'b0, "R6 exact 2.0 no inexact");
    checkOne(64'hC1E0_0000_0010_0000, 1'b0, NE, S_MIN_W, 1'b0, 1'b1, "R6 -2^31-0.5 nearest-even");
    checkOne(64'hC1E0_0000_0010_0000, 1'b0, UP, S_MIN_W, 1'b0, 1'b1, "R6 -2^31-0.5 up");
  endtask

  task automatic testSignedSat();
    checkOne(64'h41E0_0000_0000_0000, 1'b0, NE, S_MAX_W, 1'b1, 1'b0, "R7 2^31 signed");
    checkOne(64'hC1E0_0000_0020_0000, 1'b0, NE, S_MIN_W, 1'b1, 1'b0, "R7 -2^31-1 signed");
    checkOne(64'h4202_A05F_2000_0000, 1'b0, TZ, S_MAX_W, 1'b1, 1'b0, "R7 1e10 signed");
    checkOne(64'h41E6_5A0B_C000_0000, 1'b0, NE, S_MAX_W, 1'b1, 1'b0, "R7 3e9 signed");
  endtask

  task automatic testUnsignedSat();
    checkOne(64'h41F0_0000_0000_0000, 1'b1, NE, ONES, 1'b1, 1'b0, "R8 2^32 unsigned");
    checkOne(64'hBFF0_0000_0000_0000, 1'b1, NE, 64'd0, 1'b1, 1'b0, "R8 -1.0 unsigned");
    checkOne(64'hBFD0_0000_0000_0000, 1'b1, TZ, 64'd0, 1'b0, 1'b1, "R8 -0.25 unsigned to zero");
    checkOne(64'hBFD0_0000_0000_0000, 1'b1, DN, 64'd0, 1'b1, 1'b0, "R8 -0.25 unsigned down");
  endtask

  task automatic testNan();
    checkOne(64'h7FF8_0000_0000_0000, 1'b0, NE, S_MAX_W, 1'b1, 1'b0, "R9 quiet NaN signed");
    checkOne(64'hFFF0_0000_0000_0001, 1'b1, NE, ONES, 1'b1, 1'b0, "R9 negative NaN unsigned");
  endtask

  task automatic testInf();
    checkOne(64'h7FF0_0000_0000_0000, 1'b0, NE, S_MAX_W, 1'b1, 1'b0, "R10 +inf signed");
    checkOne(64'hFFF0_0000_0000_0000, 1'b0, NE, S_MIN_W, 1'b1, 1'b0, "R10 -inf signed");
    checkOne(64'h7FF0_0000_0000_0000, 1'b1, NE, ONES, 1'b1, 1'b0, "R10 +inf unsigned");
    checkOne(64'hFFF0_0000_0000_0000, 1'b1, NE, 64'd0, 1'b1, 1'b0, "R10 -inf unsigned");
  endtask

  task automatic testZeroSub();
    checkOne(64'h0000_0000_0000_0000, 1'b0, NE, 64'd0, 1'b0, 1'b0, "R11 +0");
    checkOne(64'h8000_0000_0000_0000, 1'b1, DN, 64'd0, 1'b0, 1'b0, "R11 -0 unsigned");
    checkOne(64'h0000_0000_0000_0001, 1'b0, NE, 64'd0, 1'b0, 1'b1, "R11 subnormal nearest");
    checkOne(64'h0000_0000_0000_0001, 1'b0, UP, 64'd1, 1'b0, 1'b1, "R11 subnormal up");
  endtask

  task automatic testCollide();
    checkOne(64'h41DF_FFFF_FFE0_0000, 1'b0, NE, S_MAX_W, 1'b1, 1'b0, "R12 2^31-0.5 carry saturates");
    checkOne(64'h41DF_FFFF_FFE0_0000, 1'b0, TZ, S_MAX_W, 1'b0, 1'b1, "R12 2^31-0.5 truncated");
    checkOne(64'h41EF_FFFF_FFF0_0000, 1'b1, UP, ONES, 1'b1, 1'b0, "R12 2^32-0.5 unsigned up");
    checkOne(64'h41EF_FFFF_FFF0_0000, 1'b1, TZ, ONES, 1'b0, 1'b1, "R12 2^32-0.5 unsigned truncated");
    checkOne(64'hC1E0_0000_0010_0000, 1'b0, DN, S_MIN_W, 1'b1, 1'b0, "R12 -2^31-0.5 down");
    checkOne(64'hC1E0_0000_0010_0000, 1'b0, MM, S_MIN_W, 1'b1, 1'b0, "R12 -2^31-0.5 ties-away");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testLatency();
    testSignedLimits();
    testUnsignedWiden();
    testRounding();
    testSignedSat();
    testUnsignedSat();
    testNan();
    testInf();
    testZeroSub();
    testCollide();
    repeat (2) @(posedge clk);
    finish_run();
  end

  initial begin
    #100000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end
endmodule